// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block sits between a processor core and a small 2048-location peripheral I/O space. It drives that space's active-low select strobe and stretches each access by a number of wait states. The core presents a request pulse with an 11-bit I/O address and a read/write flag. The block latches the access and picks one of four 3-bit wait-state registers. Each register governs one quarter of the address space, and address bits 10:9 choose which one. The block then holds the strobe low until the programmed count runs out. Wait states are inserted with no per-access software action.

A separate write port loads the four wait registers. The core treats `io_ready_o` as its end-of-access signal and stays stalled while the strobe is low and ready is not yet high. One access is in flight at a time. A new request is taken only when the block is idle.

Top module: `io_wait_gen`

## Requirements
- R1: After synchronous reset, `io_sel_n_o` is 1, `io_ready_o` is 0, and all four wait registers hold 7. An access anywhere then keeps the strobe low for 8 cycles.
- R2: A request seen at a rising edge while idle drives `io_sel_n_o` to 0 from the next cycle. In that same cycle `io_addr_o` equals the request address and `io_wr_o` equals the request flag (1 = write, 0 = read). Both stay constant until the access ends.
- R3: Address bits 10:9 select the wait register. 0x000–0x1FF uses register 0, 0x200–0x3FF uses register 1, 0x400–0x5FF uses register 2, and 0x600–0x7FF uses register 3.
- R4: With N wait states selected, `io_sel_n_o` stays low for exactly N+1 cycles. `io_ready_o` is 1 only in the last of them.
- R5: With zero wait states the access takes one cycle. `io_ready_o` is 1 in the first and only strobe cycle.
- R6: The strobe returns high in the cycle after `io_ready_o`, and at least one idle cycle separates accesses. A request raised while an access is in flight is dropped, not queued.
- R7: When `cfg_we_i` is 1 at a rising edge, `cfg_wdata_i` is stored in the register numbered by `cfg_sel_i` (0–3). The new value applies to the next access accepted after that edge.
- R8: A register write during an access does not change the length of that access.
- R9: The region and the address are captured when the request is accepted. Later changes on `io_addr_i` or `io_wr_i` do not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| io_req_i | input | 1 | Access request from the core |
| io_addr_i | input | 11 | I/O address of the request |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| cfg_we_i | input | 1 | Wait register write enable |
| cfg_sel_i | input | 2 | Wait register number |
| cfg_wdata_i | input | 3 | Wait state count to store |
| io_sel_n_o | output | 1 | Active-low I/O select strobe |
| io_addr_o | output | 11 | Latched address forwarded to the I/O space |
| io_wr_o | output | 1 | Latched read/write flag |
| io_ready_o | output | 1 | High in the final cycle of an access |

## Verification
The bench visits the first and last address of every region. A decoder that used the wrong address bits would then give the wrong strobe length at a region boundary. Zero-wait and maximum-wait accesses expose off-by-one errors in the counter, which would show as a strobe one cycle too long or too short or as ready in the wrong cycle. A register rewritten in mid-access and an address changed in mid-access show whether the count and address are latched at the start rather than read live. A request held high across an access, or pulsed during one, shows whether the block skips its idle cycle or queues requests it should drop.

// File: rtl/io_wait_pkg.sv
// Package: shared defaults and the access state type for the I/O wait-state
// generator. Assumes a four-region, 11-bit I/O space by default.
package io_wait_pkg;
    localparam int IO_AW_DEF  = 11;
    localparam int WAIT_W_DEF = 3;
    localparam int NREG_DEF   = 4;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_BUSY = 1'b1
    } acc_state_e;
endpackage

// File: rtl/io_wait_regs.sv
// Module: bank of wait-state registers with a single write port.
// Assumes writes are one register per cycle; every register resets to all ones.
module io_wait_regs #(
    parameter int NREG   = io_wait_pkg::NREG_DEF,
    parameter int WAIT_W = io_wait_pkg::WAIT_W_DEF,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WAIT_W-1:0] wdata,
    output logic [WAIT_W-1:0] wait_q [NREG]
);
    localparam logic [WAIT_W-1:0] WAIT_RST = {WAIT_W{1'b1}};

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Holds one region's wait count; loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wait_q[i] <= WAIT_RST;
            else if (we && (sel == SEL_W'(i)))
                wait_q[i] <= wdata;
        end
    end

    // R7
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> wait_q[$past(sel)] == $past(wdata));
endmodule

// File: rtl/io_region_dec.sv
// Module: decodes the top address bits into a region and selects that
// region's wait count. Assumes NREG is a power of two covering the space.
module io_region_dec #(
    parameter int IO_AW  = io_wait_pkg::IO_AW_DEF,
    parameter int NREG   = io_wait_pkg::NREG_DEF,
    parameter int WAIT_W = io_wait_pkg::WAIT_W_DEF,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [IO_AW-1:0]  addr,
    input  logic [WAIT_W-1:0] wait_q [NREG],
    output logic [WAIT_W-1:0] wait_sel
);
    logic [SEL_W-1:0] region;
    logic [NREG-1:0]  hit;

    assign region = addr[IO_AW-1 -: SEL_W];

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (region == SEL_W'(i));
    end

    // Merges the one-hot region hits into the selected wait count.
    always_comb begin
        wait_sel = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) wait_sel = wait_sel | wait_q[i];
        // R3
        region_onehot_chk: assert ($onehot(hit));
    end
endmodule

// File: rtl/io_wait_ctr.sv
// Module: access sequencer. Latches an accepted request, holds the strobe low
// and counts down the wait states, raising ready in the last cycle.
// Assumes the request is sampled only while idle.
module io_wait_ctr #(
    parameter int IO_AW  = io_wait_pkg::IO_AW_DEF,
    parameter int WAIT_W = io_wait_pkg::WAIT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [IO_AW-1:0]  addr_in,
    input  logic              wr_in,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              sel_n,
    output logic [IO_AW-1:0]  addr_out,
    output logic              wr_out,
    output logic              ready
);
    import io_wait_pkg::*;

    acc_state_e        state;
    logic [WAIT_W-1:0] cnt;

    // Sequences accept, count-down and completion of one access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACC_IDLE;
            cnt      <= '0;
            addr_out <= '0;
            wr_out   <= 1'b0;
        end else if (state == ACC_IDLE) begin
            if (req) begin
                state    <= ACC_BUSY;
                cnt      <= wait_in;
                addr_out <= addr_in;
                wr_out   <= wr_in;
            end
        end else if (cnt == '0) begin
            state <= ACC_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign sel_n = (state == ACC_IDLE);
    assign ready = (state == ACC_BUSY) && (cnt == '0);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && req) |=> !sel_n && addr_out == $past(addr_in) && wr_out == $past(wr_in));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !ready) |=> !sel_n && $stable(addr_out) && $stable(wr_out));
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R6
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> sel_n && !ready);
endmodule

// File: rtl/io_wait_gen.sv
// Module: top of the region-based I/O wait-state generator. Joins the wait
// register bank, the region decoder and the access sequencer.
// Assumes one access in flight at a time and a core that stalls until ready.
module io_wait_gen #(
    parameter int IO_AW  = io_wait_pkg::IO_AW_DEF,
    parameter int WAIT_W = io_wait_pkg::WAIT_W_DEF,
    parameter int NREG   = io_wait_pkg::NREG_DEF,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req_i,
    input  logic [IO_AW-1:0]  io_addr_i,
    input  logic              io_wr_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [WAIT_W-1:0] cfg_wdata_i,
    output logic              io_sel_n_o,
    output logic [IO_AW-1:0]  io_addr_o,
    output logic              io_wr_o,
    output logic              io_ready_o
);
    logic [WAIT_W-1:0] wait_q [NREG];
    logic [WAIT_W-1:0] wait_sel;

    io_wait_regs #(.NREG(NREG), .WAIT_W(WAIT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we_i),
        .sel    (cfg_sel_i),
        .wdata  (cfg_wdata_i),
        .wait_q (wait_q)
    );

    io_region_dec #(.IO_AW(IO_AW), .NREG(NREG), .WAIT_W(WAIT_W)) u_dec (
        .addr     (io_addr_i),
        .wait_q   (wait_q),
        .wait_sel (wait_sel)
    );

    io_wait_ctr #(.IO_AW(IO_AW), .WAIT_W(WAIT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (io_req_i),
        .addr_in  (io_addr_i),
        .wr_in    (io_wr_i),
        .wait_in  (wait_sel),
        .sel_n    (io_sel_n_o),
        .addr_out (io_addr_o),
        .wr_out   (io_wr_o),
        .ready    (io_ready_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> io_sel_n_o && !io_ready_o);
endmodule

// File: tb/tb_io_wait_gen.sv
module tb_io_wait_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req_i = 1'b0;
    logic [10:0] io_addr_i = '0;
    logic        io_wr_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [2:0]  cfg_wdata_i = '0;
    logic        io_sel_n_o;
    logic [10:0] io_addr_o;
    logic        io_wr_o;
    logic        io_ready_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    io_wait_gen dut (.*);

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Entry: {addr[10:0], wr, expected waits[2:0]} with regs 0..3 = 2,0,5,3
    localparam logic [14:0] VEC [10] = '{
        {11'h000, 1'b0, 3'd2}, {11'h1FF, 1'b1, 3'd2},
        {11'h200, 1'b0, 3'd0}, {11'h3FF, 1'b1, 3'd0},
        {11'h400, 1'b0, 3'd5}, {11'h5FF, 1'b1, 3'd5},
        {11'h600, 1'b0, 3'd3}, {11'h7FF, 1'b1, 3'd3},
        {11'h2A5, 1'b1, 3'd0}, {11'h555, 1'b0, 3'd5}
    };

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [2:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = s; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // One access; mid_wr rewrites register 0 to 6 during it (R8).
    task automatic run_access(input logic [10:0] a, input logic w, input int expn,
                              input logic mid_wr, input string rq);
        @(negedge clk);
        io_req_i = 1'b1; io_addr_i = a; io_wr_i = w;
        @(negedge clk);
        io_req_i = 1'b0; io_addr_i = ~a; io_wr_i = ~w; // R9: change after accept
        for (int k = 0; k <= expn; k++) begin
            if (mid_wr && k == 0) begin cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 3'd6; end
            if (mid_wr && k == 1) cfg_we_i = 1'b0;
            chk(io_sel_n_o == 1'b0, {rq, " R4 strobe low"}, io_sel_n_o, 0);
            chk(io_addr_o == a, {rq, " R2/R9 addr"}, io_addr_o, a);
            chk(io_wr_o == w, {rq, " R2/R9 wr"}, io_wr_o, w);
            chk(io_ready_o == (k == expn), {rq, " R4 ready"}, io_ready_o, k == expn);
            if (k < expn) @(negedge clk);
        end
        @(negedge clk);
        cfg_we_i = 1'b0;
        chk(io_sel_n_o == 1'b1, {rq, " R6 strobe released"}, io_sel_n_o, 1);
        chk(io_ready_o == 1'b0, {rq, " R6 ready low"}, io_ready_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(io_sel_n_o == 1'b1, "R1 sel_n in reset", io_sel_n_o, 1);
        chk(io_ready_o == 1'b0, "R1 ready in reset", io_ready_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(io_sel_n_o == 1'b1, "R1 sel_n after reset", io_sel_n_o, 1);
        // R1: default 7 wait states in every region
        run_access(11'h000, 1'b0, 7, 1'b0, "R1 default r0");
        run_access(11'h7FF, 1'b1, 7, 1'b0, "R1 default r3");

        // R7: program registers, then walk the table (R3, R4, R5)
        cfg_write(2'd0, 3'd2);
        cfg_write(2'd1, 3'd0);
        cfg_write(2'd2, 3'd5);
        cfg_write(2'd3, 3'd3);
        for (int v = 0; v < 10; v++)
            run_access(VEC[v][14:4], VEC[v][3], int'(VEC[v][2:0]), 1'b0, "R3 table");

        // R8: write register 0 during its own access; R7: next access uses it
        run_access(11'h010, 1'b0, 2, 1'b1, "R8 mid write");
        run_access(11'h020, 1'b1, 6, 1'b0, "R7 new value");

        // R5 / R6: request held high -> idle cycle between zero-wait accesses
        @(negedge clk);
        io_req_i = 1'b1; io_addr_i = 11'h210; io_wr_i = 1'b0;
        @(negedge clk);
        chk(io_sel_n_o == 1'b0 && io_ready_o == 1'b1, "R5 zero-wait one cycle", io_ready_o, 1);
        @(negedge clk);
        chk(io_sel_n_o == 1'b1, "R6 idle gap", io_sel_n_o, 1);
        @(negedge clk);
        chk(io_sel_n_o == 1'b0, "R6 reaccept after gap", io_sel_n_o, 0);
        io_req_i = 1'b0;
        @(negedge clk);
        chk(io_sel_n_o == 1'b1, "R6 end second", io_sel_n_o, 1);

        // R6: request pulsed mid-access is dropped
        @(negedge clk);
        io_req_i = 1'b1; io_addr_i = 11'h400; io_wr_i = 1'b1;
        @(negedge clk);
        io_req_i = 1'b0;
        @(negedge clk);
        io_req_i = 1'b1; io_addr_i = 11'h000;
        @(negedge clk);
        io_req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(io_ready_o == 1'b1 && io_addr_o == 11'h400, "R6 busy access completes", io_addr_o, 11'h400);
        @(negedge clk);
        chk(io_sel_n_o == 1'b1, "R6 dropped req (1)", io_sel_n_o, 1);
        @(negedge clk);
        chk(io_sel_n_o == 1'b1, "R6 dropped req (2)", io_sel_n_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule